// File: doc/BRIEF.md
# ROM Header Integrity Checker

This block inspects the header of a device description ROM as its bytes stream past. A `start` pulse opens a new image. Bytes then arrive one per accepted cycle, starting with byte 0. The checker captures the 64-bit identifier, the vendor and model numbers, the revision byte and the payload length field. It verifies an 8-bit checksum over the identifier and a CRC-32C over the payload whose length the header declares. It also compares the declared image size with the number of bytes actually streamed.

The byte that carries `in_last` closes the image. Two clock edges after that byte is accepted, the checker raises `done` for one cycle and presents a verdict. The verdict splits problems by severity:

- **Fatal:** identifier checksum wrong, size inconsistent, or stream truncated.
- **Warnings:** payload checksum wrong, or revision unknown. Warnings are only reported for an image that has no fatal error.

The verdict and the captured fields stay unchanged until the next `start`. Fetching the bytes and decoding the entries after the header are handled elsewhere.

Top module: `rom_hdr_check`

## Requirements
- R1: A `start` pulse clears every flag and field, drops any byte presented in the same cycle, and abandons an image in progress. An abandoned image never produces `done`.
- R2: Byte 0 must equal the 8-bit checksum of bytes 1..8. The checksum starts at 0xFF. For each byte, XOR the byte in, then do eight left shifts, XORing in 0x07 after any shift whose outgoing bit was 1. A mismatch sets `err_uid_crc`, but only when at least 9 bytes arrived.
- R3: Bytes 9..12 hold, least significant byte first, the reflected CRC-32C of the payload. The CRC uses polynomial 0x82F63B78, starts at all ones, and is inverted at the end. The payload starts at byte 13 and is `len` bytes long. A mismatch sets `warn_data_crc`.
- R4: `len` is bits 9:0 of the little-endian 16-bit value in bytes 14 and 15. The total size is `len`+13. If at least 16 bytes arrived and either the total is below 22 or the stream has more bytes than the total, `err_size` is set.
- R5: If the stream ends before byte 16 arrives, or with fewer bytes than the total size, `err_trunc` is set.
- R6: A revision byte (byte 13) above 2 sets `warn_rev`. A value of 2 or less does not.
- R7: `uid_o` takes bytes 1..8 with byte 1 as the least significant. `vendor_o` takes bytes 16..17 and `model_o` takes bytes 18..19, both little-endian. `revision_o` is byte 13 and `payload_len_o` is `len`.
- R8: `err_fatal` is the OR of `err_uid_crc`, `err_size` and `err_trunc`. Both warnings are forced low whenever `err_fatal` is set.
- R9: `done` is high for exactly one cycle, two rising edges after the edge that accepts the last byte. The verdict holds until the next `start`.
- R10: Bytes offered when no image is open are ignored and change no output.
- R11: Idle cycles (`in_valid` low) may appear between bytes without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new image |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the image |
| uid_o | output | 64 | Identifier |
| vendor_o | output | 16 | Vendor number |
| model_o | output | 16 | Model number |
| revision_o | output | 8 | Revision byte |
| payload_len_o | output | 10 | Declared payload length |
| done | output | 1 | Verdict ready pulse |
| err_fatal | output | 1 | Any fatal error |
| err_uid_crc | output | 1 | Identifier checksum mismatch |
| err_size | output | 1 | Size inconsistency |
| err_trunc | output | 1 | Stream too short |
| warn_data_crc | output | 1 | Payload CRC mismatch |
| warn_rev | output | 1 | Unknown revision |

## Verification
The assertions check properties that hold on every cycle:

- `done` is a single-cycle pulse, and it always follows an accepted last byte by two edges.
- Warnings never coexist with a fatal flag, and a fatal flag always has a cause.
- `start` leaves a clean verdict behind it.
- The captured fields stay still while no image is open.

The correctness of the checksum arithmetic, the size and truncation boundaries, the field byte order and the handling of a restarted image can only be shown by the bench. It compares whole streamed images against values computed independently, covering both random and directed cases.

// File: rtl/rom_hdr_check.sv
module rom_hdr_check #(
  parameter int          LEN_W         = 10,
  parameter int          PAYLOAD_START = 13,
  parameter int          HDR_BYTES     = 22,
  parameter int          MAX_REV       = 2,
  parameter logic [7:0]  POLY8         = 8'h07,
  parameter logic [31:0] POLY32        = 32'h82F63B78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  output logic [63:0]       uid_o,
  output logic [15:0]       vendor_o,
  output logic [15:0]       model_o,
  output logic [7:0]        revision_o,
  output logic [LEN_W-1:0]  payload_len_o,
  output logic              done,
  output logic              err_fatal,
  output logic              err_uid_crc,
  output logic              err_size,
  output logic              err_trunc,
  output logic              warn_data_crc,
  output logic              warn_rev
);
  localparam int POS_W = LEN_W + 2;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  function automatic logic [7:0] c8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] v;
    v = c ^ b;
    for (int i = 0; i < 8; i++) v = v[7] ? ((v << 1) ^ POLY8) : (v << 1);
    return v;
  endfunction

  function automatic logic [31:0] c32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] v;
    v = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) v = v[0] ? ((v >> 1) ^ POLY32) : (v >> 1);
    return v;
  endfunction

  logic             busy, fin;
  logic [POS_W-1:0] pos;
  logic [7:0]       uid_ref, crc8_q;
  logic [31:0]      crc32_q, crc32_ref;
  logic [15:0]      len_field;

  wire              take  = in_valid && busy && !start;
  wire [POS_W-1:0]  total = POS_W'(len_field[LEN_W-1:0]) + POS_W'(PAYLOAD_START);
  wire              in_pay = (pos >= POS_W'(PAYLOAD_START)) && (pos < POS_W'(16) || pos < total);

  wire trunc_c = (pos < POS_W'(16)) || (pos < total);
  wire size_c  = (pos >= POS_W'(16)) && ((total < POS_W'(HDR_BYTES)) || (pos > total));
  wire uid_c   = (pos >= POS_W'(9)) && (crc8_q != uid_ref);
  wire fatal_c = trunc_c || size_c || uid_c;

  assign payload_len_o = len_field[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      busy <= start; fin <= 1'b0; pos <= '0; done <= 1'b0;
      crc8_q <= 8'hFF; crc32_q <= '1; crc32_ref <= '0; uid_ref <= '0;
      uid_o <= '0; vendor_o <= '0; model_o <= '0; revision_o <= '0; len_field <= '0;
      err_fatal <= 1'b0; err_uid_crc <= 1'b0; err_size <= 1'b0; err_trunc <= 1'b0;
      warn_data_crc <= 1'b0; warn_rev <= 1'b0;
    end else begin
      done <= fin;
      fin  <= 1'b0;
      if (fin) begin
        err_trunc     <= trunc_c;
        err_size      <= size_c;
        err_uid_crc   <= uid_c;
        err_fatal     <= fatal_c;
        warn_data_crc <= !fatal_c && (~crc32_q != crc32_ref);
        warn_rev      <= !fatal_c && (revision_o > 8'(MAX_REV));
      end
      if (take) begin
        if (pos != POS_MAX) pos <= pos + 1'b1;
        if (in_last) begin busy <= 1'b0; fin <= 1'b1; end
        if (in_pay) crc32_q <= c32_step(crc32_q, in_byte);
        case (pos)
          POS_W'(0):  uid_ref <= in_byte;
          POS_W'(1), POS_W'(2), POS_W'(3), POS_W'(4),
          POS_W'(5), POS_W'(6), POS_W'(7), POS_W'(8): begin
            uid_o[(int'(pos) - 1) * 8 +: 8] <= in_byte;
            crc8_q <= c8_step(crc8_q, in_byte);
          end
          POS_W'(9), POS_W'(10), POS_W'(11), POS_W'(12):
            crc32_ref[(int'(pos) - 9) * 8 +: 8] <= in_byte;
          POS_W'(13): revision_o       <= in_byte;
          POS_W'(14): len_field[7:0]   <= in_byte;
          POS_W'(15): len_field[15:8]  <= in_byte;
          POS_W'(16): vendor_o[7:0]    <= in_byte;
          POS_W'(17): vendor_o[15:8]   <= in_byte;
          POS_W'(18): model_o[7:0]     <= in_byte;
          POS_W'(19): model_o[15:8]    <= in_byte;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rom_hdr_check_sva.sv
module rom_hdr_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic        in_last,
  input logic        busy,
  input logic        done,
  input logic        err_fatal,
  input logic        err_uid_crc,
  input logic        err_size,
  input logic        err_trunc,
  input logic        warn_data_crc,
  input logic        warn_rev,
  input logic [63:0] uid_o,
  input logic [15:0] vendor_o,
  input logic [15:0] model_o
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last && busy && !start, 2)); // R9
  AST_WARN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_data_crc || warn_rev) |-> !err_fatal); // R8
  AST_FATAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> (err_uid_crc || err_size || err_trunc)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !err_fatal && !err_uid_crc && !err_size && !err_trunc && !warn_data_crc && !warn_rev); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(uid_o) && $stable(vendor_o) && $stable(model_o)); // R10
endmodule

bind rom_hdr_check rom_hdr_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_last(in_last),
  .busy(busy), .done(done), .err_fatal(err_fatal), .err_uid_crc(err_uid_crc),
  .err_size(err_size), .err_trunc(err_trunc), .warn_data_crc(warn_data_crc),
  .warn_rev(warn_rev), .uid_o(uid_o), .vendor_o(vendor_o), .model_o(model_o)
);

// File: tb/rom_hdr_check_test.sv
`timescale 1ns/1ps
module rom_hdr_check_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic [63:0] uid_o; logic [15:0] vendor_o, model_o; logic [7:0] revision_o;
  logic [9:0] payload_len_o;
  logic done, err_fatal, err_uid_crc, err_size, err_trunc, warn_data_crc, warn_rev;

  rom_hdr_check uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] rom [0:63];
  int n_bytes;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_crc8();
    logic [7:0] v = 8'hFF;
    for (int i = 1; i <= 8; i++) begin
      v ^= rom[i];
      for (int j = 0; j < 8; j++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  function automatic logic [31:0] m_crc32(int tot);
    logic [31:0] v = '1;
    for (int i = 13; i < tot; i++) begin
      v ^= {24'd0, rom[i]};
      for (int j = 0; j < 8; j++) v = v[0] ? ((v >> 1) ^ 32'h82F63B78) : (v >> 1);
    end
    return ~v;
  endfunction

  function automatic int m_total();
    return int'({rom[15][1:0], rom[14]}) + 13;
  endfunction

  task automatic make_rom(int len, logic [7:0] rev);
    for (int i = 0; i < 64; i++) rom[i] = 8'($urandom);
    rom[13] = rev;
    rom[14] = len[7:0];
    rom[15] = {rom[15][7:2], len[9:8]};
    rom[0] = m_crc8();
    {rom[12], rom[11], rom[10], rom[9]} = m_crc32(len + 13);
  endtask

  task automatic feed_bytes(int n, bit gaps, bit with_last);
    for (int i = 0; i < n; i++) begin
      if (gaps) while ($urandom_range(0, 2) == 0) begin
        in_valid = 1'b0; @(negedge clk);
      end
      in_valid = 1'b1; in_byte = rom[i]; in_last = with_last && (i == n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; in_valid = 1'b1; in_byte = 8'hA5; @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_image(string tag, int n, bit gaps);
    int tot; bit et, es, eu, ef;
    pulse_start();
    feed_bytes(n, gaps, 1'b1);
    check({tag, " R9 done early"}, 64'(done), 64'd0);
    @(negedge clk);
    check({tag, " R9 done"}, 64'(done), 64'd1);
    tot = m_total();
    et = (n < 16) || (n < tot);
    es = (n >= 16) && ((tot < 22) || (n > tot));
    eu = (n >= 9) && (m_crc8() != rom[0]);
    ef = et || es || eu;
    check({tag, " R5 trunc"}, 64'(err_trunc), 64'(et));
    check({tag, " R4 size"}, 64'(err_size), 64'(es));
    check({tag, " R2 uid crc"}, 64'(err_uid_crc), 64'(eu));
    check({tag, " R8 fatal"}, 64'(err_fatal), 64'(ef));
    check({tag, " R3 data crc"}, 64'(warn_data_crc),
          64'(!ef && (m_crc32(tot) != {rom[12], rom[11], rom[10], rom[9]})));
    check({tag, " R6 rev"}, 64'(warn_rev), 64'(!ef && rom[13] > 8'd2));
    if (n >= 20) begin
      check({tag, " R7 uid"}, uid_o, {rom[8], rom[7], rom[6], rom[5], rom[4], rom[3], rom[2], rom[1]});
      check({tag, " R7 vendor"}, 64'(vendor_o), 64'({rom[17], rom[16]}));
      check({tag, " R7 model"}, 64'(model_o), 64'({rom[19], rom[18]}));
      check({tag, " R7 rev"}, 64'(revision_o), 64'(rom[13]));
      check({tag, " R7 len"}, 64'(payload_len_o), 64'({rom[15][1:0], rom[14]}));
    end
    @(negedge clk);
    check({tag, " R9 done pulse"}, 64'(done), 64'd0);
    check({tag, " R9 hold"}, 64'(err_fatal), 64'(ef));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] keep_uid; logic keep_f;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset fatal", 64'(err_fatal), 64'd0);
    check("R1 reset uid", uid_o, 64'd0);
    rst_n = 1'b1; @(negedge clk);

    make_rom(20, 8'd1); run_image("good", 33, 1'b0);
    make_rom(9, 8'd2);  run_image("R6 min len rev2", 22, 1'b0);
    make_rom(30, 8'd3); run_image("R6 rev3", 43, 1'b0);
    make_rom(15, 8'd0); rom[0] ^= 8'h10; run_image("R2 bad uid", 28, 1'b0);
    make_rom(15, 8'd0); rom[21] ^= 8'h01; run_image("R3 bad payload", 28, 1'b1);
    make_rom(8, 8'd0);  run_image("R4 too small", 21, 1'b0);
    make_rom(12, 8'd0); run_image("R4 too long", 26, 1'b0);
    make_rom(12, 8'd0); run_image("R5 short", 24, 1'b0);
    make_rom(12, 8'd0); run_image("R5 before len", 15, 1'b0);
    make_rom(12, 8'd0); run_image("R5 tiny", 5, 1'b0);

    make_rom(12, 8'd0);
    pulse_start(); feed_bytes(10, 1'b0, 1'b0);
    make_rom(18, 8'd1);
    run_image("R1 restart", 31, 1'b1);

    keep_uid = uid_o; keep_f = err_fatal;
    for (int i = 0; i < 6; i++) begin rom[i] = 8'($urandom); end
    feed_bytes(6, 1'b0, 1'b1);
    repeat (3) begin
      check("R10 no done idle", 64'(done), 64'd0);
      @(negedge clk);
    end
    check("R10 uid kept", uid_o, keep_uid);
    check("R10 flags kept", 64'(err_fatal), 64'(keep_f));

    for (int it = 0; it < 60; it++) begin
      int len, n, kind;
      kind = $urandom_range(0, 6);
      len = $urandom_range(9, 40);
      make_rom(len, 8'($urandom_range(0, 2)));
      n = len + 13;
      case (kind)
        1: rom[0] ^= 8'($urandom_range(1, 255));
        2: rom[13 + $urandom_range(0, len - 1)] ^= 8'h80;
        3: make_rom(len, 8'($urandom_range(3, 255)));
        4: n = len + 13 + $urandom_range(1, 3);
        5: n = $urandom_range(1, len + 12);
        6: begin len = $urandom_range(0, 8); make_rom(len, 8'd0); n = len + 13; end
        default: ;
      endcase
      run_image("R11 random", n, 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule